// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of general-purpose input pins split into groups of equal width (four groups of eight by default). Each pin passes through a synchronizer and then an edge detector that catches both rising and falling edges. A per-pin enable bit decides whether that pin may mark its group as pending. Each group holds one sticky pending flag. The flag raises that group's interrupt request only while the group's enable bit and the global interrupt enable input are both high.

Software sees the block through a small register port with a combinational read path. There is one 8-bit pin-enable register per group at addresses 0 to NUM_GROUPS-1. The group-enable register sits at address NUM_GROUPS and the pending-flag register at NUM_GROUPS+1. In both, bit g belongs to group g. A pending flag clears in two ways: software writes a one to its bit, or the interrupt dispatcher pulses an acknowledge together with the index of the group it is servicing.

Top module: `pin_change_irq`

## Requirements
- R1: During and after reset, every pin-enable register, the group-enable register and the pending-flag register read as zero, and irq_o is zero.
- R2: A level change in either direction on a pin whose pin-enable bit is one sets the pending flag of that pin's group. Pin g*8+b belongs to group g and is controlled by bit b of pin-enable register g. If the pin changes before rising clock edge k, the flag reads one after edge k+2 and still reads zero after edge k+1.
- R3: A change on a pin whose pin-enable bit is zero never sets any pending flag, even when other pins of the same group are enabled.
- R4: irq_o[g] is one exactly when pending flag g, group-enable bit g and gie_i are all one.
- R5: A clock cycle with ack_i high clears the pending flag selected by ack_vec_i and leaves the other flags unchanged.
- R6: A write to the pending-flag register clears every flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R7: If a qualifying change and a clear (acknowledge or write-one) reach the same flag in the same cycle, the flag stays set.
- R8: A pending flag is set even while its group-enable bit is zero, so software can poll it.
- R9: The pin values seen on the first synchronized samples after reset never set a flag, even if a pin-enable bit is set in the first cycle after reset.
- R10: Each pin-enable register reads back the last value written to it.
- R11: Writing ones to the pending-flag register never sets a flag. The group-enable register reads back only its low NUM_GROUPS bits, and unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_GROUPS*GROUP_W | Raw pin levels, group g in bits g*GROUP_W upward |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Dispatcher acknowledge pulse |
| ack_vec_i | input | VEC_W | Group index being acknowledged |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | GROUP_W | Register write data |
| reg_rdata_o | output | GROUP_W | Register read data, combinational |
| irq_o | output | NUM_GROUPS | Per-group interrupt request |

## Verification
The bench builds the block with its defaults: four groups of eight pins, a two-stage synchronizer and a 3-bit address. At this size every one of the 32 pins can be toggled in both directions with its enable bit both set and cleared. Every combination of the 4-bit group enable and the global enable can also be applied while all flags are pending. The small size also lets the bench hit exact cycle latencies, such as a clear that lands on the set cycle and a pin-enable written in the first cycle after reset.

// File: rtl/pin_change_irq_pkg.sv
`timescale 1ns/1ps
package pin_change_irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_EN   = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_change_sync.sv
`timescale 1ns/1ps
module pin_change_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] chg_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;
  logic [STAGES:0]          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
      vld_q  <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
      vld_q  <= {vld_q[STAGES-1:0], 1'b1};
    end
  end

  // compare only once prev_q holds a real sample
  assign chg_o = (stg_q[STAGES-1] ^ prev_q) & {W{vld_q[STAGES]}};

  assert_no_early_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q[STAGES] |-> chg_o == '0);
  assert_valid_monotonic_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q[STAGES] |=> vld_q[STAGES]);
endmodule

// File: rtl/pin_change_regs.sv
`timescale 1ns/1ps
module pin_change_regs
  import pin_change_irq_pkg::*;
#(
  parameter int G  = 4,
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic [G-1:0]   flags_i,
  output logic [G*W-1:0] masks_o,
  output logic [G-1:0]   en_o,
  output logic [G-1:0]   flag_clr_o,
  output logic [W-1:0]   rdata_o
);
  localparam int EN_ADDR   = G;
  localparam int FLAG_ADDR = G + 1;

  logic [G-1:0][W-1:0] mask_q;
  logic [G-1:0]        en_q;
  reg_sel_e            sel;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == AW'(EN_ADDR))        sel = SEL_EN;
    else if (addr_i == AW'(FLAG_ADDR)) sel = SEL_FLAG;
    else if (int'(addr_i) < G)         sel = SEL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      if (sel == SEL_EN) en_q <= wdata_i[G-1:0];
      for (int g = 0; g < G; g++)
        if (sel == SEL_MASK && addr_i == AW'(g)) mask_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_EN:   rdata_o = W'(en_q);
      SEL_FLAG: rdata_o = W'(flags_i);
      SEL_MASK:
        for (int g = 0; g < G; g++)
          if (addr_i == AW'(g)) rdata_o = mask_q[g];
      default:  rdata_o = '0;
    endcase
  end

  assign masks_o    = mask_q;
  assign en_o       = en_q;
  assign flag_clr_o = (we_i && sel == SEL_FLAG) ? wdata_i[G-1:0] : '0;

  generate
    for (genvar g = 0; g < G; g++) begin : g_chk
      assert_mask_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == AW'(g)) |=> masks_o[g*W +: W] == $past(wdata_i));
    end
  endgenerate
  assert_enable_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == AW'(EN_ADDR)) |=> $stable(en_o));
endmodule

// File: rtl/pin_change_group.sv
`timescale 1ns/1ps
module pin_change_group #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] chg_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic set, flag_q;

  assign set = |(chg_i & mask_i);

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(chg_i & mask_i) |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (chg_i & mask_i) == '0) |=> !flag_o);
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (chg_i & mask_i) == '0) |=> flag_o == $past(flag_o));
endmodule

// File: rtl/pin_change_irq.sv
`timescale 1ns/1ps
module pin_change_irq #(
  parameter int NUM_GROUPS  = 4,
  parameter int GROUP_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int VEC_W       = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_GROUPS*GROUP_W-1:0] pins_i,
  input  logic                          gie_i,
  input  logic                          ack_i,
  input  logic [VEC_W-1:0]              ack_vec_i,
  input  logic                          reg_we_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [GROUP_W-1:0]            reg_wdata_i,
  output logic [GROUP_W-1:0]            reg_rdata_o,
  output logic [NUM_GROUPS-1:0]         irq_o
);
  localparam int NPINS = NUM_GROUPS * GROUP_W;

  logic [NPINS-1:0]      masks, chg;
  logic [NUM_GROUPS-1:0] en, flags, wr_clr, clr;

  pin_change_regs #(.G(NUM_GROUPS), .W(GROUP_W), .AW(ADDR_W)) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flags_i(flags), .masks_o(masks), .en_o(en),
    .flag_clr_o(wr_clr), .rdata_o(reg_rdata_o)
  );

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      pin_change_sync #(.W(GROUP_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i, .rst_ni,
        .pin_i(pins_i[g*GROUP_W +: GROUP_W]),
        .chg_o(chg[g*GROUP_W +: GROUP_W])
      );

      assign clr[g] = wr_clr[g] | (ack_i && ack_vec_i == VEC_W'(g));

      pin_change_group #(.W(GROUP_W)) grp_i (
        .clk_i, .rst_ni,
        .chg_i(chg[g*GROUP_W +: GROUP_W]),
        .mask_i(masks[g*GROUP_W +: GROUP_W]),
        .clr_i(clr[g]),
        .flag_o(flags[g])
      );

      assign irq_o[g] = flags[g] & en[g] & gie_i;

      assert_irq_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[g] |-> (gie_i && en[g]));
      assert_masked_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flags[g]) |-> $past((chg[g*GROUP_W +: GROUP_W] & masks[g*GROUP_W +: GROUP_W]) != '0));
    end
  endgenerate

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> irq_o == '0);
endmodule

// File: tb/pin_change_irq_tb_top.sv
`timescale 1ns/1ps
module pin_change_irq_tb_top;
  localparam int G  = 4;
  localparam int W  = 8;
  localparam int AW = 3;
  localparam int VW = 2;
  localparam logic [AW-1:0] EN_A = AW'(G);
  localparam logic [AW-1:0] FL_A = AW'(G + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [G*W-1:0] pins = '0;
  logic gie = 1'b0, ack = 1'b0, we = 1'b0;
  logic [VW-1:0] ack_vec = '0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [G-1:0] irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_change_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .gie_i(gie),
    .ack_i(ack), .ack_vec_i(ack_vec), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse(int v);
    ack = 1'b1; ack_vec = VW'(v);
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    logic [W-1:0] d;
    pins = '1;
    cyc(2);
    // R1: reset state
    for (int a = 0; a < G + 2; a++) begin
      rd(AW'(a), d);
      chk("R1", "register reset value", d, 0);
    end
    chk("R1", "irq in reset", irq, 0);
    // R9: release reset with pins high, enable group 0 pins at once
    we = 1'b1; addr = '0; wdata = 8'hFF;
    rst_n = 1'b1;
    @(negedge clk);
    we = 1'b0;
    cyc(6);
    rd(FL_A, d);
    chk("R9", "no flag from first samples", d, 0);
    chk("R1", "irq after reset", irq, 0);

    // R10: pin-enable readback
    for (int g = 0; g < G; g++) begin
      for (int k = 0; k < 2; k++) begin
        logic [W-1:0] pat;
        pat = (k == 0) ? 8'hA5 ^ W'(g) : 8'h3C ^ W'(g << 4);
        wr(AW'(g), pat);
        rd(AW'(g), d);
        chk("R10", "mask readback", d, pat);
      end
    end
    // R11: enable width and unused addresses
    wr(EN_A, 8'hFF);
    rd(EN_A, d);
    chk("R11", "enable readback width", d, 8'h0F);
    wr(EN_A, 8'h00);
    for (int a = G + 2; a < (1 << AW); a++) begin
      rd(AW'(a), d);
      chk("R11", "unused address", d, 0);
    end
    for (int g = 0; g < G; g++) wr(AW'(g), 8'h00);
    cyc(2);

    // R2/R3: every pin, both masks, alternating direction
    for (int p = 0; p < G * W; p++) begin
      for (int m = 0; m < 2; m++) begin
        int g, b;
        g = p / W; b = p % W;
        wr(AW'(g), (m == 1) ? W'(1 << b) : ~W'(1 << b));
        pins[p] = ~pins[p];
        cyc(2);
        rd(FL_A, d);
        chk(m == 1 ? "R2" : "R3", "flag before latency", d, 0);
        cyc(1);
        rd(FL_A, d);
        chk(m == 1 ? "R2" : "R3", $sformatf("flag pin %0d", p), d, (m == 1) ? (1 << g) : 0);
        wr(FL_A, 8'h0F);
      end
      wr(AW'(p / W), 8'h00);
    end

    // R8: flags set with group enable clear
    for (int g = 0; g < G; g++) wr(AW'(g), 8'hFF);
    for (int g = 0; g < G; g++) pins[g*W] = ~pins[g*W];
    cyc(3);
    rd(FL_A, d);
    chk("R8", "flags with enables off", d, 8'h0F);
    chk("R8", "no irq with enables off", irq, 0);

    // R4: sweep group enable and global enable
    for (int e = 0; e < 16; e++) begin
      for (int gi = 0; gi < 2; gi++) begin
        wr(EN_A, W'(e));
        gie = gi[0];
        #1;
        chk("R4", $sformatf("irq en=%0h gie=%0d", e, gi), irq, gi ? e : 0);
      end
    end

    // R5: acknowledge clears only the selected flag
    ack_pulse(2);
    rd(FL_A, d);
    chk("R5", "ack group 2", d, 8'h0B);
    // R6: write-one clear, zero no effect
    wr(FL_A, 8'h00);
    rd(FL_A, d);
    chk("R6", "write zero keeps flags", d, 8'h0B);
    wr(FL_A, 8'h05);
    rd(FL_A, d);
    chk("R6", "write one clears", d, 8'h0A);
    ack_pulse(1);
    ack_pulse(3);
    rd(FL_A, d);
    chk("R5", "ack groups 1 and 3", d, 0);
    // R11: writing ones never sets
    wr(FL_A, 8'h0F);
    rd(FL_A, d);
    chk("R11", "write ones does not set", d, 0);

    // R7: set wins against ack
    pins[1] = ~pins[1];
    cyc(3);
    pins[1] = ~pins[1];
    cyc(2);
    ack_pulse(0);
    rd(FL_A, d);
    chk("R7", "set beats ack", d, 8'h01);
    ack_pulse(0);
    rd(FL_A, d);
    chk("R5", "plain ack clears", d, 0);
    // R7: set wins against write-one
    pins[9] = ~pins[9];
    cyc(3);
    pins[9] = ~pins[9];
    cyc(2);
    wr(FL_A, 8'h02);
    rd(FL_A, d);
    chk("R7", "set beats write-one", d, 8'h02);
    wr(FL_A, 8'h02);
    rd(FL_A, d);
    chk("R6", "write-one clears after", d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule